// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers level-sensitive interrupt sources into groups of eight and gives every group its own output line toward a parent interrupt controller. Source number n belongs to group n / 8, at position n mod 8 inside that group. A group's line is high while at least one of its enabled sources is high. It falls once every enabled source has dropped, or once software has disabled the sources that were still high.

Software reaches the enable bits and the masked status through a single-cycle register port. Each 16-byte bank serves four consecutive groups, and each of those groups owns one byte lane in every register of the bank. An enable bit is never written directly: one register turns bits on and a second register turns them off, so two software agents can manage separate sources without a read-modify-write. The source inputs are asynchronous and pass through a two-stage synchronizer before they reach any logic. The number of groups is a parameter.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `irq_o` bit is low and `reg_rdata` is 0.
- R2: Group g uses bank g / 4, whose base address is (g / 4) * 0x10. Inside each register word of that bank, group g occupies bits [8*(g mod 4)+7 : 8*(g mod 4)], and bit i of that byte refers to source 8*g + i.
- R3: A write to bank offset 0x0 sets every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to bank offset 0x4 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: A read of bank offset 0xC returns the status word, in which each bit is the synchronized source level ANDed with its enable bit. Writes to 0xC change nothing.
- R6: A read of offset 0x0 or of offset 0x4 returns the bank's current enable word.
- R7: `irq_o[g]` is the OR of group g's eight status bits. It is a level: it stays high for as long as any enabled source of the group stays high.
- R8: A source level that is present at a rising edge of `clk` reaches the status bits and `irq_o` after the second rising edge, and not before.
- R9: These accesses are unmapped: offset 0x8, any offset that is not 0x0, 0x4 or 0xC, and any bank at or beyond ceil(NUM_GROUPS/4). An unmapped access reads 0 and ignores writes. The byte lanes of groups at or above NUM_GROUPS read 0 and ignore writes.
- R10: Read data is registered. It shows the value sampled at the edge that accepted the read, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_GROUPS*8 | Asynchronous level interrupt sources |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 selects write, 0 selects read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_GROUPS | One level interrupt line per group |

## Verification
Two events can land on the same clock edge. One is a register write that changes enable bits. The other is a source level arriving from the second synchronizer stage. On that edge a group's line may rise, fall or stay unchanged, depending on which of the two events wins. The bench drives source toggles and set or clear writes to the same groups on the same edge, both directed and in a long pseudo-random run. It checks `irq_o` and `reg_rdata` on every cycle against a behavioural model, which applies the read first, then the write, then the synchronizer shift.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
    localparam int LANE_W          = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int WORD_W          = LANE_W * GROUPS_PER_BANK;

    localparam logic [3:0] OFS_SET  = 4'h0;
    localparam logic [3:0] OFS_CLR  = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'hC;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_SET,
        REG_CLR,
        REG_STAT
    } reg_kind_e;
endpackage

// File: rtl/cmb_sync.sv
module cmb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage1_q <= '0;
        else        stage1_q <= async_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage2_q <= '0;
        else        stage2_q <= stage1_q;
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/cmb_group.sv
module cmb_group
    import combiner_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lvl_i,
    input  logic [LANE_W-1:0] set_m_i,
    input  logic [LANE_W-1:0] clr_m_i,
    output logic [LANE_W-1:0] en_o,
    output logic [LANE_W-1:0] stat_o,
    output logic              irq_o
);
    logic [LANE_W-1:0] en_q;
    logic [LANE_W-1:0] en_d;

    always_comb begin
        en_d = (en_q | set_m_i) & ~clr_m_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o   = en_q;
    assign stat_o = lvl_i & en_q;
    assign irq_o  = |stat_o;

    // R3
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m_i != '0 && clr_m_i == '0) |=> ((en_q & $past(set_m_i)) == $past(set_m_i)));

    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m_i != '0) |=> ((en_q & $past(clr_m_i)) == '0));

    // R9
    idle_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m_i == '0 && clr_m_i == '0) |=> $stable(en_q));

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/cmb_regif.sv
module cmb_regif
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_en,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [WORD_W-1:0]            reg_wdata,
    input  logic [NUM_GROUPS*LANE_W-1:0] en_all_i,
    input  logic [NUM_GROUPS*LANE_W-1:0] stat_all_i,
    output logic [NUM_GROUPS*LANE_W-1:0] set_m_o,
    output logic [NUM_GROUPS*LANE_W-1:0] clr_m_o,
    output logic [WORD_W-1:0]            reg_rdata
);
    localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int BANK_W    = ADDR_W - 4;
    localparam int SRC_W     = NUM_GROUPS * LANE_W;
    localparam int PAD_W     = NUM_BANKS * WORD_W;

    logic [BANK_W-1:0] bank;
    logic [3:0]        ofs;
    logic              bank_ok;
    reg_kind_e         kind;
    logic              rd_acc;
    logic              wr_acc;
    logic [PAD_W-1:0]  en_pad;
    logic [PAD_W-1:0]  stat_pad;
    logic [WORD_W-1:0] en_word;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] rd_next;
    logic [WORD_W-1:0] rdata_q;

    assign bank    = reg_addr[ADDR_W-1:4];
    assign ofs     = reg_addr[3:0];
    assign bank_ok = ({{(32-BANK_W){1'b0}}, bank} < 32'(NUM_BANKS));
    assign rd_acc  = reg_en && !reg_we;
    assign wr_acc  = reg_en && reg_we;

    always_comb begin
        kind = REG_NONE;
        if (bank_ok) begin
            unique case (ofs)
                OFS_SET:  kind = REG_SET;
                OFS_CLR:  kind = REG_CLR;
                OFS_STAT: kind = REG_STAT;
                default:  kind = REG_NONE;
            endcase
        end
    end

    assign en_pad   = PAD_W'(en_all_i);
    assign stat_pad = PAD_W'(stat_all_i);

    always_comb begin
        en_word   = '0;
        stat_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_W'(b)) begin
                en_word   = en_pad[b*WORD_W +: WORD_W];
                stat_word = stat_pad[b*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        unique case (kind)
            REG_SET, REG_CLR: rd_next = en_word;
            REG_STAT:         rd_next = stat_word;
            default:          rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_next;
    end

    assign reg_rdata = rdata_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
        localparam int BK = g / GROUPS_PER_BANK;
        localparam int LN = g % GROUPS_PER_BANK;
        logic hit;
        assign hit = wr_acc && (bank == BANK_W'(BK));
        assign set_m_o[g*LANE_W +: LANE_W] =
            (hit && kind == REG_SET) ? reg_wdata[LN*LANE_W +: LANE_W] : '0;
        assign clr_m_o[g*LANE_W +: LANE_W] =
            (hit && kind == REG_CLR) ? reg_wdata[LN*LANE_W +: LANE_W] : '0;
    end

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && kind == REG_NONE) |=> (reg_rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(reg_rdata));

    // R5
    stat_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (kind == REG_STAT || kind == REG_NONE)) |-> (set_m_o == '0 && clr_m_o == '0));

    // R2
    one_bank_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |-> (set_m_o == SRC_W'(0) && clr_m_o == SRC_W'(0)));
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*8-1:0]      src_i,
    input  logic                         reg_en,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic [NUM_GROUPS-1:0]        irq_o
);
    localparam int SRC_W = NUM_GROUPS * LANE_W;

    logic [SRC_W-1:0] lvl;
    logic [SRC_W-1:0] en_all;
    logic [SRC_W-1:0] stat_all;
    logic [SRC_W-1:0] set_m;
    logic [SRC_W-1:0] clr_m;

    cmb_sync #(.WIDTH(SRC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (lvl)
    );

    cmb_regif #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .en_all_i   (en_all),
        .stat_all_i (stat_all),
        .set_m_o    (set_m),
        .clr_m_o    (clr_m),
        .reg_rdata  (reg_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cmb_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (lvl[g*LANE_W +: LANE_W]),
            .set_m_i (set_m[g*LANE_W +: LANE_W]),
            .clr_m_i (clr_m[g*LANE_W +: LANE_W]),
            .en_o    (en_all[g*LANE_W +: LANE_W]),
            .stat_o  (stat_all[g*LANE_W +: LANE_W]),
            .irq_o   (irq_o[g])
        );
    end

    // R1
    quiet_without_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> (irq_o == '0));
endmodule

// File: tb/irq_group_combiner_test.sv
module irq_group_combiner_test;
    localparam int CLK_PERIOD = 10;
    localparam int NG  = 6;
    localparam int NS  = NG * 8;
    localparam int NB  = (NG + 3) / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NS-1:0] m_en, m_s1, m_s2;
    logic [31:0]   m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] w;
        int bk, of;
        w  = '0;
        bk = int'(a[7:4]);
        of = int'(a[3:0]);
        if (bk >= NB) return '0;
        for (int l = 0; l < 4; l++) begin
            int g;
            g = bk * 4 + l;
            if (g < NG) begin
                if (of == 0 || of == 4) w[l*8 +: 8] = m_en[g*8 +: 8];
                else if (of == 12)      w[l*8 +: 8] = m_s2[g*8 +: 8] & m_en[g*8 +: 8];
            end
        end
        return w;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int bk, of;
        bk = int'(a[7:4]);
        of = int'(a[3:0]);
        if (bk >= NB) return;
        for (int l = 0; l < 4; l++) begin
            int g;
            g = bk * 4 + l;
            if (g < NG) begin
                if (of == 0) m_en[g*8 +: 8] = m_en[g*8 +: 8] | d[l*8 +: 8];
                if (of == 4) m_en[g*8 +: 8] = m_en[g*8 +: 8] & ~d[l*8 +: 8];
            end
        end
    endtask

    function automatic logic [NG-1:0] model_irq();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = |(m_s2[g*8 +: 8] & m_en[g*8 +: 8]);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle reference model: read, then write, then synchronizer shift
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_s1 = '0; m_s2 = '0; m_rdata = '0;
        end else begin
            if (reg_en && !reg_we) m_rdata = model_read(reg_addr);
            if (reg_en && reg_we)  model_write(reg_addr, reg_wdata);
            m_s2 = m_s1;
            m_s1 = src;
        end
        #2;
        check(irq_o === model_irq(), "R7 irq_o vs model", 32'(irq_o), 32'(model_irq()));
        check(reg_rdata === m_rdata, "R10 rdata vs model", reg_rdata, m_rdata);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_o == '0, "R1 irq after reset", 32'(irq_o), 0);
        check(reg_rdata == '0, "R1 rdata after reset", reg_rdata, 0);
        rd(8'h00, 32'h0, "R1 enables zero after reset");

        wr(8'h00, 32'h0000_00A5);
        rd(8'h00, 32'h0000_00A5, "R3 set word");
        wr(8'h00, 32'h0000_0002);
        rd(8'h04, 32'h0000_00A7, "R3 R6 zeros keep bits, read via clear offset");

        // R8: two-edge latency on source 0
        @(negedge clk);
        src[0] = 1'b1;
        @(negedge clk);
        check(irq_o[0] == 1'b0, "R8 not after one edge", 32'(irq_o), 0);
        @(negedge clk);
        check(irq_o[0] == 1'b1, "R8 visible after two edges", 32'(irq_o), 1);
        src[3] = 1'b1;
        idle(3);
        rd(8'h0C, 32'h0000_0001, "R5 status masks disabled source 3");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_00A7, "R5 status write inert");
        check(reg_rdata == 32'h0000_00A7 && irq_o == 6'b000001, "R7 level held",
              32'(irq_o), 1);

        // R4: clear bit 0, line drops next edge
        wr(8'h04, 32'h0000_0001);
        check(irq_o[0] == 1'b0, "R4 clear drops irq", 32'(irq_o), 0);
        rd(8'h00, 32'h0000_00A6, "R4 clear word");

        // R2: group 5 -> bank 1 lane 1 bit 7 -> source 47
        wr(8'h10, 32'h0000_8000);
        src[47] = 1'b1;
        idle(3);
        check(irq_o == 6'b100000, "R2 group 5 line", 32'(irq_o), 32'h20);
        rd(8'h1C, 32'h0000_8000, "R2 group 5 status lane");

        // R9 unmapped
        wr(8'h10, 32'hFF00_0000);
        rd(8'h10, 32'h0000_8000, "R9 missing-group lanes");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R9 offset 0x8 reads zero");
        rd(8'h00, 32'h0000_00A6, "R9 offset 0x8 write ignored");
        rd(8'h20, 32'h0, "R9 bank beyond range");
        wr(8'h01, 32'h0000_00FF);
        rd(8'h01, 32'h0, "R9 unaligned read");
        rd(8'h00, 32'h0000_00A6, "R9 unaligned write ignored");

        // R10 hold
        idle(4);
        check(reg_rdata == 32'h0000_00A6, "R10 rdata holds", reg_rdata, 32'h0000_00A6);

        // same-edge enable write and source arrival
        src = '0;
        idle(3);
        @(negedge clk);
        src[9] = 1'b1;
        idle(1);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0200;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        check(irq_o[1] == 1'b1, "R7 enable and level on same edge", 32'(irq_o), 2);

        for (int i = 0; i < 400; i++) begin
            int op;
            @(negedge clk);
            src ^= NS'({$urandom, $urandom}) & NS'({$urandom, $urandom});
            op = int'($urandom % 4);
            reg_en = (op != 3);
            reg_we = (op < 2);
            reg_addr = {4'($urandom % 3), 2'($urandom % 4), 2'b00};
            reg_wdata = $urandom & $urandom;
        end
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        idle(4);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule